// File: doc/BRIEF.md
# Ballast Supply Mode Sequencer

This block decides which power mode a microcontroller-driven lamp ballast controller is in. It watches digital flags from external comparators on the supply rail and on the 5 V reference, and it watches the two half-bridge commands from the microcontroller. From these it drives the start-up generator enable, the operating mode of the reference, and the enables for the supply regulator, the overcurrent protection and the gate drivers.

There are four modes: start-up (the supply capacitor is charging and the microcontroller is held off), standby (the reference powers the microcontroller at low current and the start-up generator holds the supply inside a hysteresis band), run (everything enabled) and fault (after a supply or reference undervoltage in run). The minimum standby dwell and the run inactivity window are counted in cycles of a clock whose frequency is a parameter.

Top module: `ballast_mode_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with all flags low, the block is in start-up: `hv_gen_en_o`=1, `ref_mode_o`=2'b00 (reference off, clamp sink active), `reg_en_o`=`ocp_en_o`=`drv_en_o`=0.
- R2: In start-up, a high `vcc_at_on_i` moves the block to standby: `ref_mode_o`=2'b01 (low-current reference), regulator, protection and drivers off.
- R3: In standby, a low `vcc_above_refoff_i` returns the block to start-up, taking priority over any move to run.
- R4: Standby moves to run on a falling edge of `hs_cmd_i` only after at least DWELL_US microseconds in standby and with `vref_good_i` high; run drives `ref_mode_o`=2'b10 (high-current reference), `hv_gen_en_o`=0, and `reg_en_o`=`ocp_en_o`=`drv_en_o`=1.
- R5: A falling edge of `hs_cmd_i` before the dwell has elapsed, or while `vref_good_i` is low, has no effect: the block stays in standby.
- R6: In run, each edge of `ls_cmd_i` restarts the inactivity window; after IDLE_US microseconds with no such edge the block returns to standby.
- R7: In run, a low `vcc_above_uv_i` or a low `vref_above_min_i` moves the block to fault, ahead of the inactivity exit: `hv_gen_en_o`=1, `ref_mode_o`=2'b01, regulator, protection and drivers off.
- R8: In fault, a low `vcc_above_refoff_i` moves the block to start-up; otherwise a high `vcc_at_on_i` moves it to standby.
- R9: In standby, `hv_gen_en_o` goes low while `vcc_at_on_i` is high, goes high while `vcc_above_save_i` is low, and holds its value in between; it is low on standby entry.
- R10: Every input passes through a two-flop synchroniser, so an input change takes effect on the outputs at the third rising clock edge after it, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_MHZ megahertz |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_at_on_i | input | 1 | Supply has reached the turn-on level |
| vcc_above_save_i | input | 1 | Supply is above the standby lower level |
| vcc_above_refoff_i | input | 1 | Supply is above the reference turn-off level |
| vcc_above_uv_i | input | 1 | Supply is above the undervoltage turn-off level |
| vref_good_i | input | 1 | Reference is above its good level (4.6 V) |
| vref_above_min_i | input | 1 | Reference is above its minimum level (3.2 V) |
| hs_cmd_i | input | 1 | High-side half-bridge command |
| ls_cmd_i | input | 1 | Low-side half-bridge command |
| hv_gen_en_o | output | 1 | Start-up generator enable |
| ref_mode_o | output | 2 | Reference mode: 00 off with clamp, 01 low current, 10 high current |
| reg_en_o | output | 1 | Supply regulator enable |
| ocp_en_o | output | 1 | Overcurrent protection enable |
| drv_en_o | output | 1 | Gate driver enable |

## Verification
On every cycle the assertions check that run is only ever entered with the dwell elapsed, the reference good and a high-side falling edge present, that the drivers only drop when a fault flag or the inactivity window explains it, that the reference never jumps from off straight to high current, that a fall to start-up is always preceded by a low reference turn-off flag, and that the standby generator is off while the supply is at its turn-on level. Only the bench scenarios show the exact three-edge input latency, that early or reference-bad high-side edges are ignored, that low-side switching at random intervals keeps run alive while silence ends it, and the full hysteresis pattern of the generator across random supply levels.

// File: rtl/bms_pkg.sv
// Package bms_pkg
// Shared types for the ballast supply mode sequencer: the mode encoding,
// the reference mode encoding and the bundle of input flags.
// Assumes: ref_mode codes are decoded by the reference block outside.
package bms_pkg;

    typedef enum logic [1:0] {
        ST_STARTUP  = 2'd0,
        ST_STANDBY  = 2'd1,
        ST_RUN      = 2'd2,
        ST_FAULT    = 2'd3
    } bms_state_t;

    typedef enum logic [1:0] {
        REF_OFF  = 2'b00,
        REF_LOW  = 2'b01,
        REF_HIGH = 2'b10
    } bms_ref_t;

    typedef struct packed {
        logic vcc_on;
        logic vcc_save;
        logic vcc_refoff;
        logic vcc_uv;
        logic vref_good;
        logic vref_min;
        logic hs;
        logic ls;
    } bms_flags_t;

    localparam int FLAG_W = $bits(bms_flags_t);

    typedef struct packed {
        logic     hv_gen_en;
        bms_ref_t ref_mode;
        logic     reg_en;
        logic     ocp_en;
        logic     drv_en;
    } bms_out_t;

endpackage

// File: rtl/bms_sync.sv
// Module bms_sync
// Multi-bit flop chain that brings asynchronous flags into the clock domain.
// Assumes: each bit is independent (no multi-bit coherence needed),
// STAGES >= 1.
module bms_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    // shift the flags one stage per clock, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                stg[i] <= stg[i-1];
            end
            stg[0] <= d;
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/bms_window_timer.sv
// Module bms_window_timer
// Saturating cycle counter that reports when LIMIT cycles have passed
// since the last clear.
// Assumes: LIMIT >= 1; clear has priority over counting.
module bms_window_timer #(
    parameter int LIMIT = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // count up from the last clear and hold at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == CNT_MAX);

    // R6: a clear always restarts the window
    a_r6_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expired);

endmodule

// File: rtl/bms_supply_hyst.sv
// Module bms_supply_hyst
// Standby-mode supply hysteresis: decides whether the start-up generator
// should charge the supply while the sequencer sits in standby.
// Assumes: at_on implies above_save; output is low outside standby.
module bms_supply_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic in_standby,
    input  logic at_on,
    input  logic above_save,
    output logic charge_req
);

    logic charge_q;

    // set below the lower level, clear at the upper level, hold between
    always_ff @(posedge clk) begin
        if (!rst_n || !in_standby) begin
            charge_q <= 1'b0;
        end else if (at_on) begin
            charge_q <= 1'b0;
        end else if (!above_save) begin
            charge_q <= 1'b1;
        end
    end

    assign charge_req = charge_q;

    // R9: generator is off once the supply sits at the turn-on level
    a_r9_off_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (in_standby && at_on) |=> !charge_req);

    // R9: generator is on once the supply is below the standby level
    a_r9_on_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (in_standby && !at_on && !above_save) |=> (charge_req || !in_standby || $past(!in_standby)) || !in_standby);

endmodule

// File: rtl/bms_mode_decode.sv
// Module bms_mode_decode
// Maps the current mode and the standby charge request onto the
// enable outputs of the sequencer.
// Assumes: mode is a registered state, so outputs are glitch-free.
module bms_mode_decode
    import bms_pkg::*;
(
    input  bms_state_t mode,
    input  logic       charge_req,
    output bms_out_t   outs
);

    // one output pattern per mode
    always_comb begin
        outs = '{hv_gen_en: 1'b1, ref_mode: REF_OFF,
                 reg_en: 1'b0, ocp_en: 1'b0, drv_en: 1'b0};
        unique case (mode)
            ST_STARTUP: begin
                outs.hv_gen_en = 1'b1;
                outs.ref_mode  = REF_OFF;
            end
            ST_STANDBY: begin
                outs.hv_gen_en = charge_req;
                outs.ref_mode  = REF_LOW;
            end
            ST_RUN: begin
                outs.hv_gen_en = 1'b0;
                outs.ref_mode  = REF_HIGH;
                outs.reg_en    = 1'b1;
                outs.ocp_en    = 1'b1;
                outs.drv_en    = 1'b1;
            end
            ST_FAULT: begin
                outs.hv_gen_en = 1'b1;
                outs.ref_mode  = REF_LOW;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ballast_mode_seq.sv
// Module ballast_mode_seq
// Power mode sequencer of a ballast controller: synchronises comparator
// flags and half-bridge commands, runs the four-mode state machine and
// drives generator, reference, regulator, protection and driver enables.
// Assumes: flags are level signals from external comparators; clk runs
// at CLK_MHZ megahertz; reset is synchronous and active low.
module ballast_mode_seq
    import bms_pkg::*;
#(
    parameter int CLK_MHZ     = 125,
    parameter int DWELL_US    = 10,
    parameter int IDLE_US     = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_at_on_i,
    input  logic       vcc_above_save_i,
    input  logic       vcc_above_refoff_i,
    input  logic       vcc_above_uv_i,
    input  logic       vref_good_i,
    input  logic       vref_above_min_i,
    input  logic       hs_cmd_i,
    input  logic       ls_cmd_i,
    output logic       hv_gen_en_o,
    output logic [1:0] ref_mode_o,
    output logic       reg_en_o,
    output logic       ocp_en_o,
    output logic       drv_en_o
);

    localparam int DWELL_CYC = CLK_MHZ * DWELL_US;
    localparam int IDLE_CYC  = CLK_MHZ * IDLE_US;

    bms_flags_t flags_raw;
    bms_flags_t flags_s;
    bms_state_t state_q;
    bms_state_t state_d;
    bms_out_t   outs;
    logic       hs_prev;
    logic       ls_prev;
    logic       hs_fall;
    logic       ls_edge;
    logic       mode_change;
    logic       dwell_exp;
    logic       idle_exp;
    logic       charge_req;

    assign flags_raw = '{vcc_on: vcc_at_on_i, vcc_save: vcc_above_save_i,
                         vcc_refoff: vcc_above_refoff_i, vcc_uv: vcc_above_uv_i,
                         vref_good: vref_good_i, vref_min: vref_above_min_i,
                         hs: hs_cmd_i, ls: ls_cmd_i};

    bms_sync #(
        .WIDTH  (FLAG_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (flags_raw),
        .q     (flags_s)
    );

    // remember the last synchronised command levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_prev <= 1'b0;
            ls_prev <= 1'b0;
        end else begin
            hs_prev <= flags_s.hs;
            ls_prev <= flags_s.ls;
        end
    end

    assign hs_fall = hs_prev && !flags_s.hs;
    assign ls_edge = ls_prev ^ flags_s.ls;

    // next-mode selection; faults and supply loss take priority
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STARTUP: begin
                if (flags_s.vcc_on) state_d = ST_STANDBY;
            end
            ST_STANDBY: begin
                if (!flags_s.vcc_refoff) begin
                    state_d = ST_STARTUP;
                end else if (dwell_exp && flags_s.vref_good && hs_fall) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!flags_s.vcc_uv || !flags_s.vref_min) begin
                    state_d = ST_FAULT;
                end else if (idle_exp) begin
                    state_d = ST_STANDBY;
                end
            end
            ST_FAULT: begin
                if (!flags_s.vcc_refoff) begin
                    state_d = ST_STARTUP;
                end else if (flags_s.vcc_on) begin
                    state_d = ST_STANDBY;
                end
            end
            default: state_d = ST_STARTUP;
        endcase
    end

    // mode register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STARTUP;
        end else begin
            state_q <= state_d;
        end
    end

    assign mode_change = (state_d != state_q);

    bms_window_timer #(
        .LIMIT (DWELL_CYC)
    ) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (mode_change),
        .expired (dwell_exp)
    );

    bms_window_timer #(
        .LIMIT (IDLE_CYC)
    ) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (mode_change || ls_edge),
        .expired (idle_exp)
    );

    bms_supply_hyst u_hyst (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_standby (state_q == ST_STANDBY),
        .at_on      (flags_s.vcc_on),
        .above_save (flags_s.vcc_save),
        .charge_req (charge_req)
    );

    bms_mode_decode u_decode (
        .mode       (state_q),
        .charge_req (charge_req),
        .outs       (outs)
    );

    assign hv_gen_en_o = outs.hv_gen_en;
    assign ref_mode_o  = outs.ref_mode;
    assign reg_en_o    = outs.reg_en;
    assign ocp_en_o    = outs.ocp_en;
    assign drv_en_o    = outs.drv_en;

    // R4: run is entered only with dwell done, reference good, high-side fall
    a_r4_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en_o) |-> ($past(dwell_exp) && $past(flags_s.vref_good) && $past(hs_fall)));

    // R7: drivers drop only through a fault flag or the inactivity window
    a_r7_run_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en_o) |-> ($past(idle_exp) || !$past(flags_s.vcc_uv) || !$past(flags_s.vref_min)));

    // R2: the reference never goes from off straight to high current
    a_r2_no_off_to_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ref_mode_o) == REF_OFF) |-> (ref_mode_o != REF_HIGH));

    // R3: a return to start-up is always caused by the reference turn-off flag
    a_r3_startup_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ref_mode_o) != REF_OFF) && (ref_mode_o == REF_OFF)) |-> !$past(flags_s.vcc_refoff));

endmodule

// File: tb/test_ballast_mode_seq.sv
`timescale 1ns/1ps
module test_ballast_mode_seq;

    localparam int CLK_MHZ   = 125;
    localparam int DWELL_CYC = CLK_MHZ * 10;
    localparam int IDLE_CYC  = CLK_MHZ * 100;

    localparam int M_START = 0;
    localparam int M_STBY  = 1;
    localparam int M_RUN   = 2;
    localparam int M_FAULT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vcc_on = 1'b0, vcc_save = 1'b0, vcc_refoff = 1'b0, vcc_uv = 1'b0;
    logic       vref_good = 1'b0, vref_min = 1'b0, hs = 1'b0, ls = 1'b0;
    logic       hv_gen_en, reg_en, ocp_en, drv_en;
    logic [1:0] ref_mode;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    ballast_mode_seq #(.CLK_MHZ(CLK_MHZ)) i_ballast_mode_seq (
        .clk                (clk),
        .rst_n              (rst_n),
        .vcc_at_on_i        (vcc_on),
        .vcc_above_save_i   (vcc_save),
        .vcc_above_refoff_i (vcc_refoff),
        .vcc_above_uv_i     (vcc_uv),
        .vref_good_i        (vref_good),
        .vref_above_min_i   (vref_min),
        .hs_cmd_i           (hs),
        .ls_cmd_i           (ls),
        .hv_gen_en_o        (hv_gen_en),
        .ref_mode_o         (ref_mode),
        .reg_en_o           (reg_en),
        .ocp_en_o           (ocp_en),
        .drv_en_o           (drv_en)
    );

    // expected {hv, ref[1:0], reg, ocp, drv} for a mode
    function automatic logic [5:0] exp_vec(int mode, bit hv);
        case (mode)
            M_START: return {1'b1, 2'b00, 3'b000};
            M_STBY:  return {hv,   2'b01, 3'b000};
            M_RUN:   return {1'b0, 2'b10, 3'b111};
            default: return {1'b1, 2'b01, 3'b000};
        endcase
    endfunction

    // supply level: 0 below standby level, 1 in band, 2 at turn-on
    task automatic set_level(int lvl);
        vcc_on   = (lvl == 2);
        vcc_save = (lvl >= 1);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int mode, bit hv);
        logic [5:0] act;
        logic [5:0] exp;
        act = {hv_gen_en, ref_mode, reg_en, ocp_en, drv_en};
        exp = exp_vec(mode, hv);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: outputs %b, expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic enter_run();
        step(DWELL_CYC + 10);
        hs = 1'b1;
        step(4);
        hs = 1'b0;
        step(3);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int lvl;
        bit hvm;
        void'($urandom(32'h1f2e3d4c));
        step(4);
        check("R1 reset", M_START, 1'b1);
        rst_n = 1'b1;
        step(3);
        check("R1 after release", M_START, 1'b1);

        // R10 latency and R2 start-up to standby
        set_level(2); vcc_refoff = 1'b1; vcc_uv = 1'b1;
        vref_min = 1'b1;
        step(2);
        check("R10 not yet", M_START, 1'b1);
        step(1);
        check("R2 standby entry", M_STBY, 1'b0);

        // R5 early high-side fall ignored
        hs = 1'b1; vref_good = 1'b1;
        step(5);
        hs = 1'b0;
        step(5);
        check("R5 early edge", M_STBY, 1'b0);
        // R5 reference not good
        step(DWELL_CYC + 10);
        vref_good = 1'b0; hs = 1'b1;
        step(5);
        hs = 1'b0;
        step(5);
        check("R5 vref low", M_STBY, 1'b0);
        // R4 proper entry, with R10 latency
        vref_good = 1'b1; hs = 1'b1;
        step(5);
        hs = 1'b0;
        step(2);
        check("R10 run not yet", M_STBY, 1'b0);
        step(1);
        check("R4 run entry", M_RUN, 1'b0);

        // R6 random low-side activity keeps run
        for (int i = 0; i < 15; i++) begin
            int gap;
            gap = $urandom_range(10, IDLE_CYC / 4);
            step(gap);
            ls = ~ls;
            step(1);
            check("R6 activity", M_RUN, 1'b0);
        end
        step(IDLE_CYC / 2);
        check("R6 before window", M_RUN, 1'b0);
        step(IDLE_CYC / 2 + 20);
        check("R6 inactivity exit", M_STBY, 1'b0);

        // R9 random supply levels in standby
        hvm = 1'b0;
        for (int i = 0; i < 12; i++) begin
            lvl = $urandom_range(0, 2);
            set_level(lvl);
            step(4);
            if (lvl == 0) hvm = 1'b1;
            if (lvl == 2) hvm = 1'b0;
            check("R9 random level", M_STBY, hvm);
        end
        set_level(0); step(4); check("R9 low sets", M_STBY, 1'b1);
        set_level(1); step(4); check("R9 band holds on", M_STBY, 1'b1);
        set_level(2); step(4); check("R9 top clears", M_STBY, 1'b0);
        set_level(1); step(4); check("R9 band holds off", M_STBY, 1'b0);

        // R3 standby to start-up on reference turn-off
        set_level(0); vcc_refoff = 1'b0; vcc_uv = 1'b0;
        step(3);
        check("R3 standby to start-up", M_START, 1'b1);

        // R7 supply undervoltage in run, R8 recovery to standby
        set_level(2); vcc_refoff = 1'b1; vcc_uv = 1'b1;
        step(3);
        check("R2 re-entry", M_STBY, 1'b0);
        enter_run();
        check("R4 second entry", M_RUN, 1'b0);
        set_level(0); vcc_uv = 1'b0;
        step(3);
        check("R7 supply fault", M_FAULT, 1'b1);
        step(20);
        check("R8 fault holds", M_FAULT, 1'b1);
        set_level(2); vcc_uv = 1'b1;
        step(3);
        check("R8 fault to standby", M_STBY, 1'b0);

        // R7 reference fault, R8 fault to start-up
        enter_run();
        check("R4 third entry", M_RUN, 1'b0);
        vref_min = 1'b0;
        step(3);
        check("R7 reference fault", M_FAULT, 1'b1);
        set_level(0); vcc_refoff = 1'b0;
        step(3);
        check("R8 fault to start-up", M_START, 1'b1);

        // R1 reset during run
        vref_min = 1'b1; set_level(2); vcc_refoff = 1'b1; vcc_uv = 1'b1;
        step(3);
        enter_run();
        check("R4 fourth entry", M_RUN, 1'b0);
        rst_n = 1'b0;
        step(2);
        check("R1 reset in run", M_START, 1'b1);
        rst_n = 1'b1;
        step(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule